// File: doc/BRIEF.md
# Serial Management Slave (Two-Wire Register Access)

This block is the device-side end of a two-wire serial management bus. A station drives a management clock and a bidirectional data line; the block oversamples both with its own system clock, takes one bit on each rising edge of the management clock and decodes fixed 32-bit frames. A frame is a start pattern, an operation code, a 5-bit device address, a 5-bit register address, two turnaround bits and 16 data bits. Frames that name this device's address can read or write a small register set: a control register, a read-only status register and a device-control register whose low five bits show the device address.

The device address comes from five strap inputs captured while hardware reset is held. After any reset, hardware or software, the block ignores everything until it has seen an unbroken run of 32 ones on the data line. Once it has, frames may follow back to back with no run of ones in front of them. The block turns on its data-line driver only while it returns read data. No data stream passes through the block, so it has no valid/ready handshake; every pin is a plain control or status level.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While `rst_n` is low, the device address is taken from `strap_addr` and then held; after reset `ctrl_word` equals 0x3100 and `an_restart` is low.
- R2: After any reset, no frame is served and `mdio_oe` stays low until 32 consecutive ones have been sampled; a zero before the 32nd one restarts the count.
- R3: After the first run of 32 ones, a frame that starts straight after the previous frame's last bit, with no ones in between, is served.
- R4: On a served read, `mdio_oe` is low during the first turnaround bit, the line is driven 0 during the second, and the 16 register bits follow most significant first.
- R5: A write to register 0x00 stores bits 14:10, 8 and 7; bits 15, 9 and 6:0 always read as 0; the block never drives the line during any write.
- R6: A frame whose address field differs from the captured address changes no register and never drives the line.
- R7: A frame is served only with start bits 01 and an operation code of 10 (read) or 01 (write); any other combination is consumed as a 32-bit frame, changes nothing and never drives the line.
- R8: Reading any register address other than 0x00, 0x01 and 0x19 returns 0x0000; writing one changes nothing.
- R9: Register 0x01 reads 0x7849 with `link_up` copied into bit 2, and writes to it have no effect.
- R10: Writing 1 to bit 9 of register 0x00 produces one single-cycle pulse on `an_restart`; the bit reads back as 0.
- R11: Writing 1 to bit 15 of register 0x00 returns registers 0x00 and 0x19 to their defaults and again requires 32 ones before the next frame is served; the captured address is kept.
- R12: Register 0x19 bits 4:0 read the captured address and ignore writes; bits 15:5 are read/write and reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low hardware reset; straps are captured while low |
| mdc | input | 1 | Management clock from the station |
| mdio_in | input | 1 | Sampled level of the management data line |
| mdio_out | output | 1 | Value driven onto the data line while enabled |
| mdio_oe | output | 1 | Driver enable for the data line |
| strap_addr | input | 5 | Device address straps |
| link_up | input | 1 | Link state reported in status bit 2 |
| ctrl_word | output | 16 | Current contents of control register 0x00 |
| an_restart | output | 1 | One-cycle pulse on a write of control bit 9 |

## Verification
The bench checks the preamble boundary: a run of only 31 ones must leave a read undriven. A design that counted one short would answer it, and one that never needed a preamble again would answer after a software reset. It sends back-to-back frames with no ones between them, which catches a design that wants a preamble on every frame. It sends frames with a wrong address, a bad start pattern and both illegal opcodes. A loose decoder would drive the line or corrupt the control register on these. The read turnaround is sampled bit by bit, and the read-only, reserved and self-clearing bits are read back after writes of all ones.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int DATA_W = 16;

  typedef enum logic [0:0] {ST_HUNT, ST_FRAME} mdio_state_e;

  localparam logic [1:0] SOF_PAT = 2'b01;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  localparam logic [REG_W-1:0] RA_CTRL = 5'h00;
  localparam logic [REG_W-1:0] RA_STAT = 5'h01;
  localparam logic [REG_W-1:0] RA_DEVC = 5'h19;
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_in,
  output logic mdc_rise,
  output logic bit_in
);
  logic [SYNC_STAGES:0]   mdc_sh;
  logic [SYNC_STAGES-1:0] dat_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_sh <= '0;
      dat_sh <= '1;
    end else begin
      mdc_sh <= {mdc_sh[SYNC_STAGES-1:0], mdc};
      dat_sh <= {dat_sh[SYNC_STAGES-2:0], mdio_in};
    end
  end

  assign mdc_rise = mdc_sh[SYNC_STAGES-1] & ~mdc_sh[SYNC_STAGES];
  assign bit_in   = dat_sh[SYNC_STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_rise,
  input  logic              bit_in,
  input  logic [PHY_W-1:0]  my_addr,
  input  logic              sw_rst,
  input  logic [DATA_W-1:0] rd_data,
  output logic [REG_W-1:0]  reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              pre_ok,
  output logic              in_frame
);
  localparam int FRAME_LEN = 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int CNT_W     = $clog2(PRE_LEN + 1);
  localparam int HDR_LAST  = 3 + PHY_W + REG_W;
  localparam int TA_FIRST  = HDR_LAST + 1;
  localparam int LAST_BIT  = FRAME_LEN - 1;
  localparam int HDR_W     = HDR_LAST + 1;

  mdio_state_e       st;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  ones;
  logic [DATA_W-2:0] in_sh;
  logic [DATA_W-1:0] out_sh;
  logic              is_rd, is_wr;
  logic [HDR_W-1:0]  hdr_now;
  logic              hit;

  assign hdr_now  = {in_sh[HDR_W-2:0], bit_in};
  assign hit      = (hdr_now[HDR_W-1 -: 2] == SOF_PAT) &&
                    (hdr_now[REG_W +: PHY_W] == my_addr);
  assign in_frame = (st == ST_FRAME);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_HUNT;
      idx      <= '0;
      ones     <= '0;
      pre_ok   <= 1'b0;
      in_sh    <= '0;
      out_sh   <= '0;
      is_rd    <= 1'b0;
      is_wr    <= 1'b0;
      reg_addr <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      mdio_out <= 1'b1;
      mdio_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (mdc_rise) begin
        case (st)
          ST_HUNT: begin
            if (bit_in) begin
              if (ones != CNT_W'(PRE_LEN)) ones <= ones + 1'b1;
              if (ones == CNT_W'(PRE_LEN - 1)) pre_ok <= 1'b1;
            end else if (pre_ok) begin
              st    <= ST_FRAME;
              idx   <= IDX_W'(1);
              in_sh <= '0;
              is_rd <= 1'b0;
              is_wr <= 1'b0;
            end else begin
              ones <= '0;
            end
          end
          default: begin
            in_sh <= {in_sh[DATA_W-3:0], bit_in};
            idx   <= idx + 1'b1;
            if (idx == IDX_W'(HDR_LAST)) begin
              is_rd    <= hit && (hdr_now[REG_W+PHY_W +: 2] == OP_READ);
              is_wr    <= hit && (hdr_now[REG_W+PHY_W +: 2] == OP_WRITE);
              reg_addr <= hdr_now[REG_W-1:0];
            end
            if (idx == IDX_W'(TA_FIRST)) begin
              if (is_rd) begin
                mdio_oe  <= 1'b1;
                mdio_out <= 1'b0;
                out_sh   <= rd_data;
              end
            end else if (idx > IDX_W'(TA_FIRST) && idx < IDX_W'(LAST_BIT)) begin
              if (is_rd) begin
                mdio_out <= out_sh[DATA_W-1];
                out_sh   <= {out_sh[DATA_W-2:0], 1'b0};
              end
            end
            if (idx == IDX_W'(LAST_BIT)) begin
              st       <= ST_HUNT;
              idx      <= '0;
              mdio_oe  <= 1'b0;
              mdio_out <= 1'b1;
              if (is_wr) begin
                wr_en   <= 1'b1;
                wr_data <= {in_sh, bit_in};
              end
            end
          end
        endcase
      end
      if (sw_rst) begin
        pre_ok <= 1'b0;
        ones   <= '0;
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter logic [DATA_W-1:0] CTRL_DEF  = 16'h3100,
  parameter logic [DATA_W-1:0] STAT_BASE = 16'h7849,
  parameter logic [DATA_W-1:0] DEVC_DEF  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHY_W-1:0]  strap_addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              link_up,
  output logic [DATA_W-1:0] rd_data,
  output logic [PHY_W-1:0]  addr_q,
  output logic [DATA_W-1:0] ctrl_word,
  output logic              an_restart,
  output logic              sw_rst
);
  localparam logic [DATA_W-1:0] CTRL_WMASK = 16'h7D80;
  localparam int                RST_BIT    = 15;
  localparam int                ANR_BIT    = 9;
  localparam int                LINK_BIT   = 2;
  localparam logic [DATA_W-1:0] DEVC_WMASK = {{(DATA_W-PHY_W){1'b1}}, {PHY_W{1'b0}}};

  logic [DATA_W-1:0] devc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= strap_addr;
      ctrl_word  <= CTRL_DEF;
      devc_q     <= DEVC_DEF & DEVC_WMASK;
      an_restart <= 1'b0;
      sw_rst     <= 1'b0;
    end else begin
      an_restart <= 1'b0;
      sw_rst     <= 1'b0;
      if (wr_en && reg_addr == RA_CTRL) begin
        if (wr_data[RST_BIT]) begin
          ctrl_word <= CTRL_DEF;
          devc_q    <= DEVC_DEF & DEVC_WMASK;
          sw_rst    <= 1'b1;
        end else begin
          ctrl_word  <= wr_data & CTRL_WMASK;
          an_restart <= wr_data[ANR_BIT];
        end
      end else if (wr_en && reg_addr == RA_DEVC) begin
        devc_q <= wr_data & DEVC_WMASK;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: rd_data = ctrl_word;
      RA_STAT: rd_data = STAT_BASE | (DATA_W'(link_up) << LINK_BIT);
      RA_DEVC: rd_data = (devc_q & DEVC_WMASK) | DATA_W'(addr_q);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_LEN     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic [PHY_W-1:0]  strap_addr,
  input  logic              link_up,
  output logic [DATA_W-1:0] ctrl_word,
  output logic              an_restart
);
  logic              mdc_rise, bit_in, sw_rst, wr_en, pre_ok, in_frame;
  logic [PHY_W-1:0]  addr_q;
  logic [REG_W-1:0]  reg_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  mdio_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
    .mdc_rise(mdc_rise), .bit_in(bit_in)
  );

  mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .bit_in(bit_in),
    .my_addr(addr_q), .sw_rst(sw_rst), .rd_data(rd_data),
    .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .pre_ok(pre_ok), .in_frame(in_frame)
  );

  mdio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .wr_en(wr_en),
    .reg_addr(reg_addr), .wr_data(wr_data), .link_up(link_up),
    .rd_data(rd_data), .addr_q(addr_q), .ctrl_word(ctrl_word),
    .an_restart(an_restart), .sw_rst(sw_rst)
  );
endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mdc_rise,
  input logic       pre_ok,
  input logic       in_frame,
  input logic       mdio_oe,
  input logic       an_restart,
  input logic [4:0] addr_q
);
  assert_no_drive_before_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_ok |-> !mdio_oe);

  assert_drive_only_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> in_frame);

  assert_oe_moves_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mdc_rise |=> $stable(mdio_oe));

  assert_restart_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |=> !an_restart);

  assert_addr_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(addr_q));
endmodule

bind mdio_mgmt_slave mdio_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .pre_ok(pre_ok),
  .in_frame(in_frame), .mdio_oe(mdio_oe), .an_restart(an_restart),
  .addr_q(addr_q)
);

// File: tb/mdio_mgmt_slave_tb_top.sv
module mdio_mgmt_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        bench_oe = 1'b0;
  logic        bench_val = 1'b1;
  logic [4:0]  strap = 5'h0B;
  logic        link_up = 1'b0;
  logic        mdio_out, mdio_oe, an_restart;
  logic [15:0] ctrl_word;
  logic        line;

  int n_tests = 0;
  int n_fail  = 0;
  int pulses  = 0;
  bit done    = 0;

  logic [15:0] exp_q[$];
  logic [15:0] act_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  assign line = mdio_oe ? mdio_out : (bench_oe ? bench_val : 1'b1);

  mdio_mgmt_slave dut_i (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(line),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .strap_addr(strap),
    .link_up(link_up), .ctrl_word(ctrl_word), .an_restart(an_restart)
  );

  always @(negedge clk) if (an_restart) pulses++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data and compares with what was captured.
  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        logic [15:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(a == e, t, 32'(a), 32'(e));
      end
    end
  end

  task automatic send_bit(input logic b, input logic rel, output logic s_oe, output logic s_line);
    bench_oe  = !rel;
    bench_val = b;
    repeat (8) @(negedge clk);
    s_oe   = mdio_oe;
    s_line = line;
    mdc = 1'b1;
    repeat (8) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) begin
      logic so, sl;
      send_bit(1'b1, 1'b0, so, sl);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] pa, input logic [4:0] ra,
                                     input logic [15:0] d);
    return {st, op, pa, ra, 2'b10, d};
  endfunction

  task automatic run_frame(input logic [31:0] bits, input bit rel_ta,
                           output logic [15:0] got, output int drv,
                           output logic ta1_oe, output logic ta2_oe, output logic ta2_val);
    got = '0; drv = 0; ta1_oe = 0; ta2_oe = 0; ta2_val = 1;
    for (int i = 0; i < 32; i++) begin
      logic so, sl;
      send_bit(bits[31-i], rel_ta && (i >= 14), so, sl);
      if (so) drv++;
      if (i == 14) ta1_oe = so;
      if (i == 15) begin ta2_oe = so; ta2_val = sl; end
      if (i >= 16) got = {got[14:0], sl};
    end
    bench_oe = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] st, input logic [1:0] op, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] d, input string req);
    logic [15:0] g; int drv; logic a, b, c;
    run_frame(mk(st, op, pa, ra, d), 1'b0, g, drv, a, b, c);
    check(drv == 0, req, 32'(drv), 32'd0);
  endtask

  task automatic do_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] e, input string req);
    logic [15:0] g; int drv; logic a, b, c;
    run_frame(mk(2'b01, 2'b10, pa, ra, 16'hFFFF), 1'b1, g, drv, a, b, c);
    check(!a && b && !c, {req, " turnaround"}, {29'd0, a, b, c}, 32'b010);
    exp_q.push_back(e);
    tag_q.push_back(req);
    act_q.push_back(g);
    @(negedge clk);
  endtask

  task automatic read_ignored(input logic [4:0] pa, input logic [4:0] ra, input string req);
    logic [15:0] g; int drv; logic a, b, c;
    run_frame(mk(2'b01, 2'b10, pa, ra, 16'hFFFF), 1'b1, g, drv, a, b, c);
    check(drv == 0, req, 32'(drv), 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(ctrl_word == 16'h3100, "R1 ctrl reset", 32'(ctrl_word), 32'h3100);
    check(an_restart == 1'b0, "R1 restart low", 32'(an_restart), 32'd0);

    // R2: 31 ones is not enough
    send_ones(31);
    read_ignored(5'h0B, 5'h00, "R2 short preamble");
    send_ones(32);
    do_read(5'h0B, 5'h19, 16'h000B, "R1 R12 strap readback");
    // R3: back-to-back frames, R4 timing checked inside do_read
    do_read(5'h0B, 5'h00, 16'h3100, "R3 R4 no preamble read");

    // R5 write with reserved bits
    do_write(2'b01, 2'b01, 5'h0B, 5'h00, 16'h4140, "R5 write no drive");
    check(ctrl_word == 16'h4100, "R5 ctrl stored", 32'(ctrl_word), 32'h4100);
    do_read(5'h0B, 5'h00, 16'h4100, "R5 readback");
    do_write(2'b01, 2'b01, 5'h0B, 5'h00, 16'h7DFF & ~16'h0200, "R5 write mask");
    do_read(5'h0B, 5'h00, 16'h7D80, "R5 reserved read zero");
    do_write(2'b01, 2'b01, 5'h0B, 5'h00, 16'h4100, "R5 restore");

    // R6 wrong address
    do_write(2'b01, 2'b01, 5'h0C, 5'h00, 16'h0000, "R6 foreign write");
    check(ctrl_word == 16'h4100, "R6 ctrl unchanged", 32'(ctrl_word), 32'h4100);
    read_ignored(5'h0C, 5'h00, "R6 foreign read");

    // R7 bad opcode / start
    do_write(2'b01, 2'b11, 5'h0B, 5'h00, 16'h0000, "R7 opcode 11");
    do_write(2'b01, 2'b00, 5'h0B, 5'h00, 16'h0000, "R7 opcode 00");
    do_write(2'b00, 2'b01, 5'h0B, 5'h00, 16'h0000, "R7 start 00");
    check(ctrl_word == 16'h4100, "R7 ctrl unchanged", 32'(ctrl_word), 32'h4100);
    do_read(5'h0B, 5'h00, 16'h4100, "R7 still in step");

    // R8 unimplemented
    do_read(5'h0B, 5'h05, 16'h0000, "R8 read empty");
    do_write(2'b01, 2'b01, 5'h0B, 5'h05, 16'hBEEF, "R8 write empty");
    do_read(5'h0B, 5'h05, 16'h0000, "R8 read after write");

    // R9 status
    link_up = 1'b1;
    do_read(5'h0B, 5'h01, 16'h784D, "R9 status link up");
    link_up = 1'b0;
    do_write(2'b01, 2'b01, 5'h0B, 5'h01, 16'h0000, "R9 status write");
    do_read(5'h0B, 5'h01, 16'h7849, "R9 status link down");

    // R10 restart pulse
    p0 = pulses;
    do_write(2'b01, 2'b01, 5'h0B, 5'h00, 16'h4300, "R10 write restart");
    repeat (4) @(negedge clk);
    check(pulses == p0 + 1, "R10 one pulse", 32'(pulses - p0), 32'd1);
    do_read(5'h0B, 5'h00, 16'h4100, "R10 bit self clears");

    // R12 device control
    do_write(2'b01, 2'b01, 5'h0B, 5'h19, 16'hFFFF, "R12 write devc");
    do_read(5'h0B, 5'h19, 16'hFFEB, "R12 devc readback");

    // R11 software reset
    do_write(2'b01, 2'b01, 5'h0B, 5'h00, 16'h8000, "R11 write reset");
    repeat (4) @(negedge clk);
    check(ctrl_word == 16'h3100, "R11 ctrl default", 32'(ctrl_word), 32'h3100);
    read_ignored(5'h0B, 5'h00, "R11 preamble needed");
    send_ones(32);
    do_read(5'h0B, 5'h19, 16'h000B, "R11 devc default");
    do_read(5'h0B, 5'h00, 16'h3100, "R11 ctrl read");

    // R1 hardware reset with new straps
    strap = 5'h1F;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    strap = 5'h02;
    repeat (2) @(negedge clk);
    send_ones(32);
    read_ignored(5'h0B, 5'h19, "R1 old address dropped");
    do_read(5'h1F, 5'h19, 16'h001F, "R1 new strap latched");

    repeat (4) @(negedge clk);
    wait (act_q.size() == 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule